// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

The block holds one wide event counter for each statistic a 10G-class MAC reports on its receive and transmit sides. Examples are good octets, unicast, multicast, broadcast, pause and jumbo frames, FCS, symbol, length and jabber errors, fragments and undersize frames. The MAC datapath raises a one-cycle strobe for each event. Octet counters also take a byte count on the same cycle. Counters with indices below `NUM_OCT` are octet counters and add the matching `ev_octets` slice. Every other counter adds one.

Software never reads the live counters. It writes a snapshot command, which copies every live counter into a holding register at once. It then reads the held values as narrow 16-bit register words. Each counter has a sticky rollover flag that records a wrap of its full width. The flags are clear-on-read, so software can extend the counters to 64 bits by polling. A rollover can also raise `irq`, which is gated by four mask words. The masks reset to zero so that polling software sees no interrupt.

The register ports are plain strobes with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read presented with `rd_en` returns `rd_data` with `rd_valid` on the next cycle. One read and one write may be issued in the same cycle.

Top module: `stat_snap_bank`

## Requirements
- R1: After reset every counter, every held value, every rollover flag and every mask word is zero. `irq` and `rd_valid` are low.
- R2: A counter with index below `NUM_OCT` adds its `OCT_W`-bit slice of `ev_octets` on each strobe. Every other counter adds one per strobe. A counter without a strobe keeps its value.
- R3: A write to address 0x000 with bit 0 set copies every live counter, as it stood before that edge, into its holding register. Held values change only on such a write, and the live counters keep counting.
- R4: Counter i is read at 0x100+4i. Offset 0 returns held bits 15:0, offset 1 returns bits 31:16, and offset 2 returns bits 39:32 in bits 7:0 with the upper byte zero. Offset 3 reads zero.
- R5: A write to 0x000 with bit 1 set zeroes every live counter. An event in the same cycle is discarded and cannot flag a wrap. When bits 0 and 1 are set together, the holding registers capture the values from before the clear.
- R6: When an increment carries out of the `CNT_W`-bit counter, the counter keeps the low bits and its rollover flag sets. Flag i is bit i%16 of the status word at 0x004+i/16.
- R7: Reading a status word returns its flags and clears them on the same edge. A wrap on that same edge leaves its flag set.
- R8: Mask word k is written and read at 0x008+k. `irq` is high exactly when some flag is set and its bit in the masks is also set.
- R9: `rd_valid` is high in the cycle after each `rd_en` and low otherwise. Unmapped addresses, address 0x000, and counter indices at or above `NUM_CNT` read zero.
- R10: A rollover flag stays set until its status word is read. A snapshot, a clear command or a read of any other address leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | NUM_CNT | One-cycle event strobe per counter |
| ev_octets | input | NUM_OCT*OCT_W | Byte count for each octet counter, valid with its strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Read data word |
| irq | output | 1 | Masked rollover interrupt |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is held low for at least one clock edge.
- An octet counter's step never exceeds its counter width (`OCT_W` ≤ `CNT_W`).
- At most one read and one write arrive per cycle.

The stimulus stays within these limits: it drives inputs only between clock edges, and it gives octet steps of up to 2^14−1. The bench narrows the counters to 18 bits so that wraps occur within a few dozen strobes. Its status reads are repeated so that some of them land on the same edge as a wrap. Full-width behaviour of the third slice is covered only by its zero value.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned FLAG_WORDS = 4;
  localparam int unsigned MAX_CNT    = REG_W * FLAG_WORDS;

  // register offsets (word addresses)
  localparam int unsigned CTRL_OFS   = 'h000;
  localparam int unsigned ROLL_OFS   = 'h004;
  localparam int unsigned MASK_OFS   = 'h008;
  localparam int unsigned CNT_OFS    = 'h100;

  // command bits in the control word
  localparam int unsigned SNAP_BIT   = 0;
  localparam int unsigned CLEAR_BIT  = 1;

  typedef enum logic [1:0] {
    SL_LOW = 2'd0,
    SL_MID = 2'd1,
    SL_TOP = 2'd2,
    SL_PAD = 2'd3
  } slice_e;

  function automatic logic [REG_W-1:0] take_slice(input logic [63:0] v, input slice_e s);
    case (s)
      SL_LOW:  return v[15:0];
      SL_MID:  return v[31:16];
      SL_TOP:  return {8'h00, v[39:32]};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int unsigned CNT_W  = 40,
  parameter int unsigned STEP_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [STEP_W-1:0] step,
  input  logic              clear,
  input  logic              snap,
  output logic [CNT_W-1:0]  live,
  output logic [CNT_W-1:0]  held,
  output logic              wrap
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] step_ext;
  logic [SUM_W-1:0] sum;

  assign step_ext = SUM_W'(step);
  assign sum      = {1'b0, live} + step_ext;
  assign wrap     = strobe & ~clear & sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      held <= '0;
    end else begin
      if (clear)       live <= '0;
      else if (strobe) live <= sum[CNT_W-1:0];
      if (snap)        held <= live;
    end
  end
endmodule

// File: rtl/stat_rollover.sv
module stat_rollover
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CNT-1:0]    wrap,
  input  logic [FLAG_WORDS-1:0] clr_word,
  output logic [MAX_CNT-1:0]    flags
);
  for (genvar b = 0; b < MAX_CNT; b++) begin : g_bit
    if (b < NUM_CNT) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr_word[b / REG_W]) | wrap[b];
      end
      assign flags[b] = q;
    end else begin : g_none
      assign flags[b] = 1'b0;
    end
  end
endmodule

// File: rtl/stat_regfile.sv
module stat_regfile
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 24,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_CNT*CNT_W-1:0] held_flat,
  input  logic [MAX_CNT-1:0]       flags,
  output logic                     snap_cmd,
  output logic                     clear_cmd,
  output logic [FLAG_WORDS-1:0]    clr_word,
  output logic [MAX_CNT-1:0]       mask,
  output logic                     rd_valid,
  output logic [REG_W-1:0]         rd_data
);
  localparam int unsigned PG_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [PG_W-1:0]   PG_ROLL = PG_W'(ROLL_OFS / 4);
  localparam logic [PG_W-1:0]   PG_MASK = PG_W'(MASK_OFS / 4);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CNT_OFS);
  localparam logic [PG_W-1:0]   N_CNT   = PG_W'(NUM_CNT);

  // write side: commands and masks
  logic ctrl_hit, mask_hit;
  assign ctrl_hit  = wr_en && (wr_addr == A_CTRL);
  assign mask_hit  = wr_en && (wr_addr[ADDR_W-1:2] == PG_MASK);
  assign snap_cmd  = ctrl_hit & wr_data[SNAP_BIT];
  assign clear_cmd = ctrl_hit & wr_data[CLEAR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)        mask <= '0;
    else if (mask_hit) mask[wr_addr[1:0]*REG_W +: REG_W] <= wr_data;
  end

  // read side: decode and select
  logic              roll_hit, mrd_hit, cnt_hit;
  logic [ADDR_W-1:0] rel;
  logic [PG_W-1:0]   idx;
  logic [CNT_W-1:0]  sel;
  logic [REG_W-1:0]  rd_word;

  assign roll_hit = rd_addr[ADDR_W-1:2] == PG_ROLL;
  assign mrd_hit  = rd_addr[ADDR_W-1:2] == PG_MASK;
  assign rel      = rd_addr - A_CNT;
  assign idx      = rel[ADDR_W-1:2];
  assign cnt_hit  = (rd_addr >= A_CNT) && (idx < N_CNT);

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (idx == PG_W'(i)) sel = held_flat[i*CNT_W +: CNT_W];
  end

  always_comb begin
    rd_word = '0;
    if (roll_hit)     rd_word = flags[rd_addr[1:0]*REG_W +: REG_W];
    else if (mrd_hit) rd_word = mask[rd_addr[1:0]*REG_W +: REG_W];
    else if (cnt_hit) rd_word = take_slice(64'(sel), slice_e'(rel[1:0]));
  end

  assign clr_word = (rd_en && roll_hit) ? (FLAG_WORDS'(1) << rd_addr[1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CNT = 24,
  parameter int unsigned NUM_OCT = 4,
  parameter int unsigned CNT_W   = 40,
  parameter int unsigned OCT_W   = 14,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       ev_strobe,
  input  logic [NUM_OCT*OCT_W-1:0] ev_octets,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [15:0]              wr_data,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic                     rd_valid,
  output logic [15:0]              rd_data,
  output logic                     irq
);
  logic [NUM_CNT*CNT_W-1:0] live_flat;
  logic [NUM_CNT*CNT_W-1:0] held_flat;
  logic [NUM_CNT-1:0]       wrap_vec;
  logic [MAX_CNT-1:0]       flags_q;
  logic [MAX_CNT-1:0]       mask_q;
  logic [FLAG_WORDS-1:0]    clr_word;
  logic                     snap_cmd, clear_cmd;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i < NUM_OCT) begin : g_oct
      stat_counter #(.CNT_W(CNT_W), .STEP_W(OCT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ev_strobe[i]),
        .step   (ev_octets[i*OCT_W +: OCT_W]),
        .clear  (clear_cmd),
        .snap   (snap_cmd),
        .live   (live_flat[i*CNT_W +: CNT_W]),
        .held   (held_flat[i*CNT_W +: CNT_W]),
        .wrap   (wrap_vec[i])
      );
    end else begin : g_frm
      stat_counter #(.CNT_W(CNT_W), .STEP_W(1)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ev_strobe[i]),
        .step   (1'b1),
        .clear  (clear_cmd),
        .snap   (snap_cmd),
        .live   (live_flat[i*CNT_W +: CNT_W]),
        .held   (held_flat[i*CNT_W +: CNT_W]),
        .wrap   (wrap_vec[i])
      );
    end
  end

  stat_rollover #(.NUM_CNT(NUM_CNT)) u_roll (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap     (wrap_vec),
    .clr_word (clr_word),
    .flags    (flags_q)
  );

  stat_regfile #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .held_flat (held_flat),
    .flags     (flags_q),
    .snap_cmd  (snap_cmd),
    .clear_cmd (clear_cmd),
    .clr_word  (clr_word),
    .mask      (mask_q),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign irq = |(flags_q & mask_q);
endmodule

// File: rtl/stat_snap_bank_chk.sv
module stat_snap_bank_chk #(
  parameter int unsigned NUM_CNT = 24,
  parameter int unsigned CNT_W   = 40
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic                     rd_valid,
  input logic                     irq,
  input logic                     snap_cmd,
  input logic                     clear_cmd,
  input logic [NUM_CNT-1:0]       wrap_vec,
  input logic [63:0]              flags_q,
  input logic [63:0]              mask_q,
  input logic [NUM_CNT*CNT_W-1:0] live_flat,
  input logic [NUM_CNT*CNT_W-1:0] held_flat
);
  p_snap_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cmd |=> (held_flat == $past(live_flat)));

  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cmd |=> $stable(held_flat));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> (live_flat == '0));

  p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((flags_q[NUM_CNT-1:0] & $past(wrap_vec)) == $past(wrap_vec)));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

bind stat_snap_bank stat_snap_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .irq       (irq),
  .snap_cmd  (snap_cmd),
  .clear_cmd (clear_cmd),
  .wrap_vec  (wrap_vec),
  .flags_q   (flags_q),
  .mask_q    (mask_q),
  .live_flat (live_flat),
  .held_flat (held_flat)
);

// File: tb/test_stat_snap_bank.sv
`timescale 1ns/1ps
module test_stat_snap_bank;
  localparam int NC = 6;
  localparam int NO = 2;
  localparam int CW = 18;
  localparam int OW = 14;
  localparam int AW = 10;
  localparam longint MODV = longint'(1) << CW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC-1:0]   ev_strobe = '0;
  logic [NO*OW-1:0] ev_octets = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [15:0]     wr_data = '0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic            rd_valid;
  logic [15:0]     rd_data;
  logic            irq;

  stat_snap_bank #(.NUM_CNT(NC), .NUM_OCT(NO), .CNT_W(CW), .OCT_W(OW), .ADDR_W(AW)) i_stat_snap_bank (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_octets(ev_octets),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  int     checks = 0;
  int     errors = 0;
  string  cur_req = "R1";
  bit     done = 0;

  // behavioural reference state
  longint      live [NC];
  longint      held [NC];
  logic [63:0] flg = '0;
  logic [63:0] msk = '0;
  bit          exp_rv = 0;
  logic [15:0] exp_rd = '0;
  bit          exp_irq = 0;

  task automatic check16(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(int a);
    longint v;
    int rel, idx, s;
    if (a >= 4 && a < 8)  return 16'((flg >> (16*(a-4))) & 64'hFFFF);
    if (a >= 8 && a < 12) return 16'((msk >> (16*(a-8))) & 64'hFFFF);
    if (a >= 256) begin
      rel = a - 256; idx = rel / 4; s = rel % 4;
      if (idx < NC) begin
        v = held[idx];
        if (s == 0) return 16'(v & 'hFFFF);
        if (s == 1) return 16'((v >> 16) & 'hFFFF);
        if (s == 2) return 16'((v >> 32) & 'hFF);
      end
    end
    return 16'h0000;
  endfunction

  // one clock: predict from current inputs, advance, compare
  task automatic tick();
    logic [63:0] wbits = '0;
    bit snap_c, clr_c;
    longint s, inc;
    int ra = int'(rd_addr);
    int wa = int'(wr_addr);
    exp_rv = rd_en;
    if (rd_en) exp_rd = model_read(ra);
    snap_c = wr_en && wa == 0 && wr_data[0];
    clr_c  = wr_en && wa == 0 && wr_data[1];
    if (snap_c) for (int i = 0; i < NC; i++) held[i] = live[i];
    for (int i = 0; i < NC; i++) begin
      if (clr_c) live[i] = 0;
      else if (ev_strobe[i]) begin
        inc = (i < NO) ? longint'(ev_octets[i*OW +: OW]) : 1;
        s = live[i] + inc;
        if (s >= MODV) begin s -= MODV; wbits[i] = 1'b1; end
        live[i] = s;
      end
    end
    if (rd_en && ra >= 4 && ra < 8) flg &= ~(64'hFFFF << (16*(ra-4)));
    flg |= wbits;
    if (wr_en && wa >= 8 && wa < 12)
      msk = (msk & ~(64'hFFFF << (16*(wa-8)))) | (64'(wr_data) << (16*(wa-8)));
    exp_irq = |(flg & msk);
    @(posedge clk); #1;
    check16("rd_valid", 16'(rd_valid), 16'(exp_rv));
    if (exp_rv) check16("rd_data", rd_data, exp_rd);
    check16("irq", 16'(irq), 16'(exp_irq));
  endtask

  task automatic cmd(bit snap, bit clr);
    wr_en = 1; wr_addr = '0; wr_data = {14'b0, clr, snap};
    tick();
    wr_en = 0;
  endtask

  task automatic wreg(int a, logic [15:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(int a);
    rd_en = 1; rd_addr = AW'(a);
    tick();
    rd_en = 0;
  endtask

  task automatic read_all();
    for (int i = 0; i <= NC; i++)
      for (int s = 0; s < 4; s++) rd(256 + 4*i + s);
  endtask

  task automatic pump(int n, logic [NC-1:0] stb, logic [OW-1:0] o0, logic [OW-1:0] o1);
    for (int k = 0; k < n; k++) begin
      ev_strobe = stb; ev_octets = {o1, o0};
      tick();
    end
    ev_strobe = '0; ev_octets = '0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(4*100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin live[i] = 0; held[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during and after reset
    check16("rd_valid in reset", 16'(rd_valid), 16'h0);
    check16("irq in reset", 16'(irq), 16'h0);
    rst_n = 1;
    cur_req = "R1";
    rd(4); rd(8); rd(256); rd(258); rd(256 + 4*NO);

    // R2: mixed strobe patterns on octet and frame counters
    cur_req = "R2";
    for (int k = 0; k < 20; k++) begin
      ev_strobe = NC'(k*7 + 3);
      ev_octets = {OW'(16383 - k*5), OW'(k*311)};
      tick();
    end
    ev_strobe = '0; ev_octets = '0;
    pump(3, 6'b101010, 14'd0, 14'd9);
    // R3/R4: snapshot then read every slice
    cur_req = "R3";
    cmd(1, 0);
    cur_req = "R4";
    read_all();

    // R3: held values frozen while live keeps counting
    cur_req = "R3";
    pump(10, 6'b111111, 14'd1000, 14'd77);
    read_all();
    cmd(1, 0);
    read_all();

    // R5: clear beats a same-cycle event; snap+clear captures pre-clear
    cur_req = "R5";
    ev_strobe = '1; ev_octets = {14'd16383, 14'd16383};
    cmd(0, 1);
    ev_strobe = '0; ev_octets = '0;
    cmd(1, 0);
    read_all();
    pump(4, 6'b110011, 14'd500, 14'd600);
    cmd(1, 1);
    read_all();
    cmd(1, 0);
    read_all();

    // R6: octet counter 1 wraps and sets flag bit 1 of word 0x004
    cur_req = "R6";
    pump(20, 6'b000010, 14'd0, 14'd16383);
    rd(4); rd(5); rd(6); rd(7);
    // R7: second read sees the cleared word
    cur_req = "R7";
    rd(4);
    // R7: wraps landing on read edges keep their flags
    for (int k = 0; k < 40; k++) begin
      ev_strobe = 6'b000011; ev_octets = {14'd16383, 14'd16001};
      rd_en = 1; rd_addr = AW'(4);
      tick();
    end
    ev_strobe = '0; ev_octets = '0; rd_en = 0;
    rd(4); rd(4);

    // R8: mask write/readback and interrupt gating
    cur_req = "R8";
    wreg(8, 16'h0002);
    wreg(11, 16'hA5C3);
    rd(8); rd(11); rd(9);
    pump(20, 6'b000001, 14'd16383, 14'd0);
    pump(20, 6'b000010, 14'd0, 14'd16383);
    rd(4);
    pump(20, 6'b000010, 14'd0, 14'd16383);
    wreg(8, 16'h0000);
    wreg(8, 16'h0002);
    rd(4);

    // R9: unmapped space and back-to-back reads
    cur_req = "R9";
    rd(0); rd(12); rd(100); rd(255); rd(256 + 4*NC + 1); rd(259);
    rd_en = 1; rd_addr = AW'(256); tick();
    rd_addr = AW'(257); tick();
    rd_en = 0; tick(); tick();

    // R10: flags survive snapshot, clear and unrelated reads
    cur_req = "R10";
    cmd(1, 0);
    pump(20, 6'b000001, 14'd16383, 14'd0);
    cmd(1, 0);
    rd(256); rd(8);
    cmd(0, 1);
    rd(4); rd(4);

    done = 1;
    summary();
    $finish;
  end
endmodule